// File: doc/BRIEF.md
# Toggle-Bit Event Queue

This block is a circular queue of 32-bit interrupt event entries held in on-chip RAM. A producer port stores event numbers and a consumer port reads them back. Neither side compares its pointer with the other's to decide whether an entry is new. The producer stamps the top bit of every entry with its current generation bit. The consumer judges the entry at its own index by comparing that stamp against a toggle it keeps locally, and the toggle inverts each time the consumer index wraps. Entries left over from the previous lap therefore read as empty without any extra storage.

After reset the consumer state machine starts in `CQ_CLEAR` and zero-fills the whole RAM, one word per cycle. The transition `CLEAR_DONE` then moves it to `CQ_READY`. In `CQ_READY` a read request is accepted through the transition `ACCEPT`, which moves to `CQ_LOOKUP` while the RAM word is fetched. `CQ_LOOKUP` always returns to `CQ_READY` through the transition `RESPOND`, and in that cycle the result is registered. A read either consumes the entry (pop) or leaves the index and toggle untouched (peek). An empty slot returns 0, and a valid entry returns its event number with bit 31 cleared. The producer refuses pushes while the RAM is being cleared. It also refuses them while the next slot still holds an entry the consumer has not taken.

Top module: `evq_top`

## Requirements
- R1: After reset the block spends exactly DEPTH cycles zero-filling the RAM. During that time `rd_ready` is low and `push_accept` is low. After the fill, a peek and a pop both return 0.
- R2: An accepted push stores `{gen, push_event}` at the producer index, where `gen` occupies bit 31, and advances the producer index modulo DEPTH. The producer generation is 1 after reset and inverts whenever the producer index wraps to 0.
- R3: `full` is high when DEPTH entries are stored and not yet consumed. While `full` is high, `push_accept` is low and a push leaves the stored entries unchanged, so later pops still return them in order.
- R4: A read request is accepted on a rising edge where `rd_ready` is high. `rd_ready` is low for the next cycle. `rsp_valid` is high for exactly one cycle, just after the following edge.
- R5: An entry is valid only when its bit 31 differs from the consumer toggle. Reading an entry that is not valid returns 0. The consumer toggle is 0 after reset.
- R6: A pop of a valid entry returns its bits 30:0 with bit 31 cleared and advances the consumer index as (index + 1) AND (DEPTH - 1).
- R7: The consumer toggle inverts exactly when the consumer index wraps to 0. Entries written on the next producer lap are then accepted, and stale entries from the lap before are rejected.
- R8: A peek (`rd_peek` = 1) returns the same value as a pop would, but leaves the consumer index and toggle unchanged, so repeated peeks return the same entry.
- R9: A pop that finds an empty slot does not advance the consumer. An event pushed later into that slot is returned by the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers an event this cycle |
| push_event | input | 31 | Event number to store |
| push_accept | output | 1 | The offered event is stored at this edge |
| full | output | 1 | Next producer slot still holds an unconsumed entry |
| rd_req | input | 1 | Read request |
| rd_peek | input | 1 | 1 = peek, 0 = pop (consume) |
| rd_ready | output | 1 | Consumer can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read result |
| rsp_data | output | 32 | Event number with bit 31 clear, or 0 when the slot is empty |

## Verification
The queue is exercised with short interleaved push and pop bursts, which show that event numbers come back in order. Pops on an empty queue show the difference between a stall and a skipped slot. Repeated peeks show the difference between a non-destructive read and a hidden advance. A full lap that crosses the index wrap with the queue full shows whether the full flag blocks overrun and whether the toggle flip accepts the new lap while rejecting stale entries. An all-ones event number shows whether bit 31 is cleared correctly. A behavioural model, built from plain arrays and integers, predicts every output on every clock.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [1:0] {
        CQ_CLEAR  = 2'd0,
        CQ_READY  = 2'd1,
        CQ_LOOKUP = 2'd2
    } cq_state_t;

endpackage

// File: rtl/evq_ram.sv
module evq_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // Read-before-write: a same-edge read returns the old word.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/evq_producer.sv
module evq_producer #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int EVT_W  = ENTRY_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               push_valid,
    input  logic [EVT_W-1:0]   push_event,
    input  logic [AW-1:0]      cons_idx,
    input  logic               cons_tog,
    output logic               push_accept,
    output logic               full,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [ENTRY_W-1:0] wr_data
);

    localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

    logic [AW-1:0] prod_idx;
    logic          prod_gen;

    // Producer has lapped the consumer when indices meet and the
    // generation it writes equals the polarity the consumer treats as stale.
    always_comb begin
        full        = (prod_idx == cons_idx) && (prod_gen == cons_tog);
        push_accept = enable && push_valid && !full;
        wr_en       = push_accept;
        wr_addr     = prod_idx;
        wr_data     = {prod_gen, push_event};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_idx <= '0;
            prod_gen <= 1'b1;
        end else if (push_accept) begin
            prod_idx <= prod_idx + AW'(1);
            if (prod_idx == IDX_LAST) begin
                prod_gen <= ~prod_gen;
            end
        end
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (prod_idx == $past(prod_idx)));                       // R3

    AST_GEN_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prod_gen) |-> (prod_idx == '0));                      // R2

endmodule

// File: rtl/evq_consumer.sv
module evq_consumer
    import evq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int EVT_W  = ENTRY_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic               rd_peek,
    output logic               rd_ready,
    output logic               clearing,
    output logic               ram_re,
    output logic [AW-1:0]      ram_raddr,
    input  logic [ENTRY_W-1:0] ram_rdata,
    output logic               clr_we,
    output logic [AW-1:0]      clr_addr,
    output logic [AW-1:0]      cons_idx,
    output logic               cons_tog,
    output logic               rsp_valid,
    output logic [ENTRY_W-1:0] rsp_data
);

    localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

    cq_state_t     state_q, state_d;
    logic [AW-1:0] clr_cnt;
    logic          op_pop;
    logic          entry_hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CQ_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: CLEAR_DONE, ACCEPT, RESPOND
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CQ_CLEAR:  if (clr_cnt == IDX_LAST) state_d = CQ_READY;
            CQ_READY:  if (rd_req)              state_d = CQ_LOOKUP;
            CQ_LOOKUP:                          state_d = CQ_READY;
            default:                            state_d = CQ_CLEAR;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        clearing  = (state_q == CQ_CLEAR);
        rd_ready  = (state_q == CQ_READY);
        ram_re    = rd_ready && rd_req;
        ram_raddr = cons_idx;
        clr_we    = clearing;
        clr_addr  = clr_cnt;
        entry_hit = (ram_rdata[ENTRY_W-1] != cons_tog);
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt   <= '0;
            op_pop    <= 1'b0;
            cons_idx  <= '0;
            cons_tog  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                CQ_CLEAR: begin
                    clr_cnt <= clr_cnt + AW'(1);
                end
                CQ_READY: begin
                    if (rd_req) begin
                        op_pop <= !rd_peek;
                    end
                end
                CQ_LOOKUP: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= entry_hit ? {1'b0, ram_rdata[EVT_W-1:0]} : '0;
                    if (entry_hit && op_pop) begin
                        cons_idx <= cons_idx + AW'(1);
                        if (cons_idx == IDX_LAST) begin
                            cons_tog <= ~cons_tog;
                        end
                    end
                end
                default: begin
                    rsp_valid <= 1'b0;
                end
            endcase
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> (!rd_ready ##1 rsp_valid));           // R4

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                     // R4

    AST_RSP_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_data[ENTRY_W-1]);                           // R6

    AST_PEEK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CQ_LOOKUP && !op_pop) |=> ($stable(cons_idx) && $stable(cons_tog))); // R8

    AST_EMPTY_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CQ_LOOKUP && ram_rdata[ENTRY_W-1] == cons_tog) |=> $stable(cons_idx)); // R9

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CQ_LOOKUP && ram_rdata[ENTRY_W-1] == cons_tog) |=> (rsp_data == '0)); // R5

    AST_TOG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_tog) |-> (cons_idx == '0));                      // R7

endmodule

// File: rtl/evq_top.sv
module evq_top #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int EVT_W  = ENTRY_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [EVT_W-1:0]   push_event,
    output logic               push_accept,
    output logic               full,
    input  logic               rd_req,
    input  logic               rd_peek,
    output logic               rd_ready,
    output logic               rsp_valid,
    output logic [ENTRY_W-1:0] rsp_data
);

    generate
        if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
            $error("evq_top: DEPTH must be a power of two of at least 2");
        end
    endgenerate

    logic               clearing;
    logic               ram_re;
    logic [AW-1:0]      ram_raddr;
    logic [ENTRY_W-1:0] ram_rdata;
    logic               clr_we;
    logic [AW-1:0]      clr_addr;
    logic [AW-1:0]      cons_idx;
    logic               cons_tog;
    logic               prd_we;
    logic [AW-1:0]      prd_addr;
    logic [ENTRY_W-1:0] prd_data;
    logic               mem_we;
    logic [AW-1:0]      mem_waddr;
    logic [ENTRY_W-1:0] mem_wdata;

    // Write port: the zero-fill owns the RAM until it finishes.
    always_comb begin
        mem_we    = clr_we | prd_we;
        mem_waddr = clearing ? clr_addr : prd_addr;
        mem_wdata = clearing ? '0 : prd_data;
    end

    evq_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    evq_producer #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_prod (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (!clearing),
        .push_valid  (push_valid),
        .push_event  (push_event),
        .cons_idx    (cons_idx),
        .cons_tog    (cons_tog),
        .push_accept (push_accept),
        .full        (full),
        .wr_en       (prd_we),
        .wr_addr     (prd_addr),
        .wr_data     (prd_data)
    );

    evq_consumer #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_cons (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_peek   (rd_peek),
        .rd_ready  (rd_ready),
        .clearing  (clearing),
        .ram_re    (ram_re),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr),
        .cons_idx  (cons_idx),
        .cons_tog  (cons_tog),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    AST_CLEAR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (!push_accept && !rd_ready));                     // R1

    AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_we && prd_we));                                          // R1

endmodule

// File: tb/tb_evq_top.sv
module tb_evq_top;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [30:0] push_event = '0;
    logic        push_accept;
    logic        full;
    logic        rd_req = 1'b0;
    logic        rd_peek = 1'b0;
    logic        rd_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    always #4 clk = ~clk;   // 125 MHz

    evq_top #(.DEPTH(DEPTH), .ENTRY_W(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_event(push_event),
        .push_accept(push_accept), .full(full),
        .rd_req(rd_req), .rd_peek(rd_peek), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mem [DEPTH];
    int          m_clr_left;
    int          m_pidx, m_cidx;
    bit          m_pgen, m_ctog;
    bit          m_busy, m_pop;
    logic [31:0] m_snap;
    bit          m_rsp_valid;
    logic [31:0] m_rsp_data;

    function automatic bit m_full();
        return (m_pidx == m_cidx) && (m_pgen == m_ctog);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clr_left  = DEPTH;
            m_pidx = 0; m_cidx = 0; m_pgen = 1; m_ctog = 0;
            m_busy = 0; m_pop = 0; m_snap = '0;
            m_rsp_valid = 0; m_rsp_data = '0;
        end else begin
            bit acc;
            bit hit;
            acc = push_valid && !m_full() && (m_clr_left == 0);
            m_rsp_valid = 0;
            if (m_busy) begin
                hit = (m_snap[31] != m_ctog);
                m_rsp_data  = hit ? {1'b0, m_snap[30:0]} : 32'h0;
                m_rsp_valid = 1;
                if (hit && m_pop) begin
                    m_cidx = (m_cidx + 1) % DEPTH;
                    if (m_cidx == 0) m_ctog = !m_ctog;
                end
                m_busy = 0;
            end else if (m_clr_left == 0 && rd_req) begin
                m_busy = 1;
                m_snap = m_mem[m_cidx];
                m_pop  = !rd_peek;
            end
            if (m_clr_left > 0) begin
                m_mem[DEPTH - m_clr_left] = 32'h0;
                m_clr_left--;
            end else if (acc) begin
                m_mem[m_pidx] = {m_pgen, push_event};
                m_pidx = (m_pidx + 1) % DEPTH;
                if (m_pidx == 0) m_pgen = !m_pgen;
            end
        end
    end

    // Compare every cycle, away from the edge.
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            chk("R4 rd_ready vs model", {31'b0, rd_ready},
                {31'b0, (m_clr_left == 0) && !m_busy});
            chk("R3 full vs model", {31'b0, full}, {31'b0, m_full()});
            chk("R1/R3 push_accept vs model", {31'b0, push_accept},
                {31'b0, push_valid && !m_full() && (m_clr_left == 0)});
            chk("R4 rsp_valid vs model", {31'b0, rsp_valid}, {31'b0, m_rsp_valid});
            chk("R5 rsp_data vs model", rsp_data, m_rsp_data);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic push(input logic [30:0] ev, input bit exp_acc, input string tag);
        @(negedge clk);
        push_valid = 1'b1;
        push_event = ev;
        #1 chk(tag, {31'b0, push_accept}, {31'b0, exp_acc});
        @(posedge clk);
        #1 push_valid = 1'b0;
    endtask

    task automatic rd(input bit peek, input logic [31:0] exp, input string tag);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_req  = 1'b1;
        rd_peek = peek;
        @(posedge clk);
        #1 rd_req = 1'b0;
        @(posedge clk);
        #2;
        chk(tag, {31'b0, rsp_valid}, 32'h1);
        chk(tag, rsp_data, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rd_ready", {31'b0, rd_ready}, 32'h0);
        chk("R4 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R3 reset full", {31'b0, full}, 32'h0);
        rst_n = 1'b1;
        push(31'h1, 1'b0, "R1 push rejected while clearing");
        @(negedge clk);
        chk("R1 not ready while clearing", {31'b0, rd_ready}, 32'h0);
        while (!rd_ready) @(negedge clk);

        rd(1'b1, 32'h0, "R1 peek after zero fill");
        rd(1'b0, 32'h0, "R5 pop on empty queue");

        push(31'h11, 1'b1, "R2 push 11");
        push(31'h22, 1'b1, "R2 push 22");
        push(31'h33, 1'b1, "R2 push 33");
        rd(1'b0, 32'h11, "R6 pop first");
        rd(1'b1, 32'h22, "R8 peek once");
        rd(1'b1, 32'h22, "R8 peek again");
        rd(1'b0, 32'h22, "R6 pop second");
        rd(1'b0, 32'h33, "R6 pop third");
        rd(1'b0, 32'h0,  "R9 pop empty");
        push(31'h44, 1'b1, "R9 push after empty pop");
        rd(1'b0, 32'h44, "R9 pop returns late entry");

        for (int i = 0; i < DEPTH; i++) begin
            push(31'(32'h100 + i), 1'b1, "R2 fill push");
        end
        @(negedge clk);
        chk("R3 full after DEPTH pushes", {31'b0, full}, 32'h1);
        push(31'h999, 1'b0, "R3 push rejected when full");
        for (int i = 0; i < DEPTH; i++) begin
            rd(1'b0, 32'h100 + i, "R7 pop across wrap");
        end
        rd(1'b0, 32'h0, "R7 stale lap entry is empty");
        push(31'h7FFFFFFF, 1'b1, "R2 push max event");
        rd(1'b0, 32'h7FFFFFFF, "R6 max event msb clear");
        rd(1'b1, 32'h0, "R5 empty after drain");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule